// File: doc/BRIEF.md
# Multiplexer Pre-Charge Phase Sequencer

This block sequences the analog front end placed between an 8:1 analog multiplexer and an ADC input. It runs a repeating four-phase cycle: connected, where the multiplexer drives the ADC node and a sample is taken; reset, where the node is pulled to ground; a break-before-make gap; and pre-charge, where a compensation capacitor lifts the node toward mid-reference. Each phase lasts a programmable number of clock cycles. The four control lines are two active-low gates for high-side switches, one active-high gate for the grounding switch and the active-low multiplexer enable. All four come from one registered word, so they change together on a single clock edge.

The block also walks the 3-bit channel address through a Gray-code sequence, so only one address bit moves per step. The address moves only when the connected phase hands over to the reset phase, which is the edge where the multiplexer output becomes isolated. A one-cycle ready strobe marks the last cycle of each connected phase, and the address being sampled is valid in that cycle. While the sequencer is stopped or held in reset, the outputs keep a safe pattern with every switch off and the multiplexer isolated.

Top module: `mux_precharge_seq`

## Requirements
- R1: While `rst` is high, `gateA`=1, `gateB`=1, `gateC`=0 and `muxEnN`=1. Also `chanAddr`=0 and `sampleRdy`=0.
- R2: The output word ({gateA,gateB,gateC,muxEnN}) is 4'b1100 in the connected phase, 4'b0111 in reset, 4'b1101 in break-before-make and 4'b1001 in pre-charge.
- R3: Phases follow the order connected, reset, break-before-make, pre-charge, then back to connected. Each phase holds its pattern for exactly as many cycles as its duration input gives. The duration inputs are read as unsigned and must stay constant while running.
- R4: `gateC`=1 and `gateB`=0 never occur in the same cycle. In the cycle before `gateB` falls, `gateC` is 0.
- R5: A duration input of 0 gives a phase of one cycle. No phase is ever skipped.
- R6: `chanAddr` starts at 0 and steps through the Gray sequence 0,1,3,2,6,7,5,4 and then wraps. It moves one step on each edge where the connected phase ends and reset begins, and at no other time. The encoding is bin ^ (bin >> 1).
- R7: `chanAddr` changes only in cycles in which `muxEnN` is 1. It is stable through the whole connected phase.
- R8: On the first edge with `runEn` low, the outputs take the safe word 4'b1101 and `sampleRdy`=0. They keep it, with `chanAddr` held, until the first edge with `runEn` high. That edge starts a full reset phase.
- R9: `sampleRdy` is 1 for exactly the last cycle of each connected phase and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Enables the phase cycle when high |
| durConn | input | 8 | Connected phase length in cycles (0 means 1) |
| durReset | input | 8 | Reset phase length in cycles (0 means 1) |
| durBbm | input | 8 | Break-before-make length in cycles (0 means 1) |
| durPre | input | 8 | Pre-charge phase length in cycles (0 means 1) |
| gateA | output | 1 | Auxiliary high-side switch gate, active low |
| gateB | output | 1 | Pre-charge switch gate, active low |
| gateC | output | 1 | Grounding switch gate, active high |
| muxEnN | output | 1 | Multiplexer enable, active low |
| chanAddr | output | 3 | Gray-coded channel address |
| sampleRdy | output | 1 | One-cycle strobe on the last connected cycle |

## Verification
The bench drives all-zero durations so that every phase lasts one cycle. A counter that compared against `dur-1` without clamping would wrap and stall a phase for 256 cycles, and a design that skipped a zero-length phase would let the pre-charge and grounding gates sit next to each other with no gap. Long runs push the address through its full Gray wrap and through restarts after `runEn` drops mid-phase. A design that advanced the address on restart, or moved it while the multiplexer was connected, would show a second changed bit or a change while `muxEnN` is low. Off-by-one errors in the phase counter or the strobe timing show up as a single-cycle mismatch against the reference model across random phase lengths.

// File: rtl/mps_pkg.sv
package mps_pkg;

  typedef enum logic [1:0] {
    PH_CONN  = 2'd0,
    PH_RESET = 2'd1,
    PH_BBM   = 2'd2,
    PH_PRE   = 2'd3
  } phase_t;

  typedef struct packed {
    logic swA;   // active low
    logic swB;   // active low
    logic swC;   // active high
    logic enN;   // active low
  } ctlWord_t;

  typedef struct packed {
    logic   run;          // sequencer allowed to run this edge
    phase_t nextPhase;    // phase taken at this edge
    logic   lastConnNext; // next cycle is final connected cycle
    logic   stepAddr;     // connected -> reset hand-over at this edge
  } seqStrobe_t;

  localparam ctlWord_t SAFE_WORD = '{swA: 1'b1, swB: 1'b1, swC: 1'b0, enN: 1'b1};

  function automatic ctlWord_t patternOf(phase_t p);
    ctlWord_t w;
    unique case (p)
      PH_CONN:  w = '{swA: 1'b1, swB: 1'b1, swC: 1'b0, enN: 1'b0};
      PH_RESET: w = '{swA: 1'b0, swB: 1'b1, swC: 1'b1, enN: 1'b1};
      PH_BBM:   w = '{swA: 1'b1, swB: 1'b1, swC: 1'b0, enN: 1'b1};
      default:  w = '{swA: 1'b1, swB: 1'b0, swC: 1'b0, enN: 1'b1};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import mps_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             runEn,
  input  logic [CNT_W-1:0] durConn,
  input  logic [CNT_W-1:0] durReset,
  input  logic [CNT_W-1:0] durBbm,
  input  logic [CNT_W-1:0] durPre,
  output seqStrobe_t       strb
);

  function automatic logic [CNT_W-1:0] lastOf(logic [CNT_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext, lastCur;
  logic             running, run;

  assign run = runEn && !rst;

  always_comb begin
    unique case (phase)
      PH_CONN:  lastCur = lastOf(durConn);
      PH_RESET: lastCur = lastOf(durReset);
      PH_BBM:   lastCur = lastOf(durBbm);
      default:  lastCur = lastOf(durPre);
    endcase
  end

  always_comb begin
    if (!run || !running) begin
      phaseNext = PH_RESET;
      cntNext   = '0;
    end else if (cnt == lastCur) begin
      phaseNext = phase_t'(phase + 2'd1);
      cntNext   = '0;
    end else begin
      phaseNext = phase;
      cntNext   = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= PH_RESET;
      cnt     <= '0;
    end else begin
      running <= run;
      phase   <= phaseNext;
      cnt     <= cntNext;
    end
  end

  assign strb.run          = run;
  assign strb.nextPhase    = phaseNext;
  assign strb.lastConnNext = run && (phaseNext == PH_CONN) && (cntNext == lastOf(durConn));
  assign strb.stepAddr     = run && running && (phase == PH_CONN) && (cnt == lastCur);

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && phase != $past(phase)) |-> (phase == phase_t'($past(phase) + 2'd1))) // R3
    else $error("phase order broken");

  AST_RESTART_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    (!running && runEn) |=> (phase == PH_RESET && cnt == '0)) // R8
    else $error("restart not in reset phase");

endmodule

// File: rtl/mps_dpath.sv
module mps_dpath
  import mps_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  output ctlWord_t          outWord,
  output logic [ADDR_W-1:0] addrGray,
  output logic              sampleRdy
);

  logic [ADDR_W-1:0] binAddr, binNext, grayNext;

  assign binNext = binAddr + 1'b1;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_gray
    if (i == ADDR_W - 1) begin : g_msb
      assign grayNext[i] = binNext[i];
    end else begin : g_low
      assign grayNext[i] = binNext[i] ^ binNext[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outWord   <= SAFE_WORD;
      binAddr   <= '0;
      addrGray  <= '0;
      sampleRdy <= 1'b0;
    end else begin
      outWord   <= strb.run ? patternOf(strb.nextPhase) : SAFE_WORD;
      sampleRdy <= strb.lastConnNext;
      if (strb.stepAddr) begin
        binAddr  <= binNext;
        addrGray <= grayNext;
      end
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(outWord.swC && !outWord.swB)) // R4
    else $error("charge and discharge switches both on");

  AST_BBM_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(outWord.swB) |-> !$past(outWord.swC)) // R4
    else $error("no gap before pre-charge");

  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(addrGray) |-> ($countones(addrGray ^ $past(addrGray)) == 1)) // R6
    else $error("address moved more than one bit");

  AST_ADDR_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    !$stable(addrGray) |-> outWord.enN) // R7
    else $error("address moved while connected");

  AST_SAFE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> (outWord == SAFE_WORD && !sampleRdy)) // R8
    else $error("unsafe pattern while stopped");

  AST_STROBE_CONNECTED: assert property (@(posedge clk) disable iff (rst)
    sampleRdy |-> !outWord.enN) // R9
    else $error("strobe outside connected phase");

endmodule

// File: rtl/mux_precharge_seq.sv
module mux_precharge_seq
  import mps_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              runEn,
  input  logic [CNT_W-1:0]  durConn,
  input  logic [CNT_W-1:0]  durReset,
  input  logic [CNT_W-1:0]  durBbm,
  input  logic [CNT_W-1:0]  durPre,
  output logic              gateA,
  output logic              gateB,
  output logic              gateC,
  output logic              muxEnN,
  output logic [ADDR_W-1:0] chanAddr,
  output logic              sampleRdy
);

  seqStrobe_t strb;
  ctlWord_t   outWord;

  mps_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .runEn    (runEn),
    .durConn  (durConn),
    .durReset (durReset),
    .durBbm   (durBbm),
    .durPre   (durPre),
    .strb     (strb)
  );

  mps_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .outWord   (outWord),
    .addrGray  (chanAddr),
    .sampleRdy (sampleRdy)
  );

  assign gateA  = outWord.swA;
  assign gateB  = outWord.swB;
  assign gateC  = outWord.swC;
  assign muxEnN = outWord.enN;

endmodule

// File: tb/sim_mux_precharge_seq.sv
module sim_mux_precharge_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       runEn = 1'b0;
  logic [7:0] durConn = 8'd40, durReset = 8'd16, durBbm = 8'd1, durPre = 8'd1;
  logic       gateA, gateB, gateC, muxEnN, sampleRdy;
  logic [2:0] chanAddr;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mux_precharge_seq u0 (
    .clk(clk), .rst(rst), .runEn(runEn),
    .durConn(durConn), .durReset(durReset), .durBbm(durBbm), .durPre(durPre),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .muxEnN(muxEnN),
    .chanAddr(chanAddr), .sampleRdy(sampleRdy)
  );

  // reference model, updated from bench-driven inputs only
  bit       mRun = 1'b0;
  int       mPhase = 1;
  int       mLeft = 0;
  int       mBin = 0;
  logic [2:0] prevAddr = 3'd0;

  function automatic int lenOf(int p);
    logic [7:0] d;
    case (p)
      0: d = durConn;
      1: d = durReset;
      2: d = durBbm;
      default: d = durPre;
    endcase
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  function automatic logic [3:0] expWord(bit running, int p);
    if (!running) return 4'b1101;
    case (p)
      0: return 4'b1100;
      1: return 4'b0111;
      2: return 4'b1101;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic logic [2:0] grayOf(int b);
    logic [2:0] v;
    v = b[2:0];
    return v ^ (v >> 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mRun = 1'b0;
      mBin = 0;
    end else if (!runEn) begin
      mRun = 1'b0;
    end else if (!mRun) begin
      mRun   = 1'b1;
      mPhase = 1;
      mLeft  = lenOf(1);
    end else begin
      mLeft = mLeft - 1;
      if (mLeft == 0) begin
        if (mPhase == 0) mBin = mBin + 1;
        mPhase = (mPhase + 1) % 4;
        mLeft  = lenOf(mPhase);
      end
    end
  end

  task automatic checkNow(string patTag);
    logic [3:0] act, exp;
    logic       expRdy;
    act = {gateA, gateB, gateC, muxEnN};
    exp = expWord(mRun, mPhase);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: control word actual %b expected %b", patTag, act, exp);
    end
    testCnt++;
    if (chanAddr !== grayOf(mBin)) begin
      failCnt++;
      $display("FAIL R6: chanAddr actual %0d expected %0d", chanAddr, grayOf(mBin));
    end
    expRdy = mRun && mPhase == 0 && mLeft == 1;
    testCnt++;
    if (sampleRdy !== expRdy) begin
      failCnt++;
      $display("FAIL R9: sampleRdy actual %b expected %b", sampleRdy, expRdy);
    end
    testCnt++;
    if (gateC === 1'b1 && gateB === 1'b0) begin
      failCnt++;
      $display("FAIL R4: gateC/gateB actual %b%b expected not 10", gateC, gateB);
    end
    testCnt++;
    if (chanAddr !== prevAddr && muxEnN !== 1'b1) begin
      failCnt++;
      $display("FAIL R7: address changed with muxEnN actual %b expected 1", muxEnN);
    end
    prevAddr = chanAddr;
  endtask

  task automatic runCycles(int n, string patTag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow(patTag);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    runEn = 1'b1;
    runCycles(3, "R1");                 // reset state
    rst = 1'b0;
    runCycles(300, "R2");               // default lengths 40/16/1/1
    runEn = 1'b0;
    runCycles(3, "R8");                 // stop mid-run
    durConn = 8'd0; durReset = 8'd0; durBbm = 8'd0; durPre = 8'd0;
    runEn = 1'b1;
    runCycles(48, "R5");                // every phase one cycle, address wraps
    for (int s = 0; s < 30; s++) begin
      runEn = 1'b0;
      runCycles(1 + int'($urandom_range(0, 3)), "R8");
      durConn  = 8'($urandom_range(0, 12));
      durReset = 8'($urandom_range(0, 9));
      durBbm   = 8'($urandom_range(0, 3));
      durPre   = 8'($urandom_range(0, 5));
      runEn = 1'b1;
      runCycles(int'($urandom_range(5, 160)), "R3");
    end
    durConn = 8'd255; durReset = 8'd1; durBbm = 8'd2; durPre = 8'd255;
    runEn = 1'b0;
    runCycles(2, "R8");
    runEn = 1'b1;
    runCycles(1100, "R3");              // largest counts
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule